// File: doc/BRIEF.md
# Embedded Operation Status Reporter

This block sits between a flash array's read path and the host bus while the device runs an internal program or erase. A program or erase start pulse arms an internal duration counter, loaded from a parameter given in clock cycles. While that counter runs, the ready output is held low. Every host read returns a status byte instead of array contents. The status byte carries a data-polling bit in the top position and a toggle bit just below it.

When the counter expires, the block goes back to passing array data through on its own, and ready returns high. An erase can be suspended so that the host can read other sectors, and then resumed. On resume the erase continues from the count it had reached, not from the start.

Each read is a single-cycle strobe with the sector number of the read address and the array word for that address. The result appears on the read-data output one cycle later.

Top module: `flash_status_reporter`

## Requirements
- R1: After synchronous reset, `ready` is 1, `rd_q` is all zeros, the block is idle and the internal toggle state is 0.
- R2: A read while a program or erase is running returns a status word: bit DW-1 is the polling bit, bit DW-2 is the toggle bit, and all lower bits are 0. The toggle bit inverts from one such read to the next.
- R3: `ready` is 0 in the cycle after an accepted start. A start pulse that arrives while an operation is running or suspended is ignored.
- R4: A program keeps `ready` low for exactly PROG_CYCLES cycles. The block then returns to array reads without any command.
- R5: While a program runs, the polling bit is the complement of bit DW-1 of the byte being programmed.
- R6: While an erase runs, the polling bit is 0. With no suspend, an erase keeps `ready` low for exactly ERASE_CYCLES cycles.
- R7: When idle, a read returns `array_q` one cycle after `rd_en`, and the toggle state is left unchanged.
- R8: A suspend request is honoured only during an erase, and `ready` is 1 in the cycle after it. A suspend request during a program has no effect. A resume request has no effect unless the erase is suspended.
- R9: After a resume, the erase runs for only the cycles that remained when it was suspended. Summed over every running interval, `ready` is low for exactly ERASE_CYCLES cycles.
- R10: While suspended, a read of any sector other than the one being erased returns `array_q`. A read of the sector being erased, or of any sector when the whole chip is being erased, returns the status word with the toggle bit held.
- R11: When a program start and an erase start arrive together in idle, the program is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_start | input | 1 | One-cycle request to begin a program |
| prog_byte | input | DW | Data being programmed |
| erase_start | input | 1 | One-cycle request to begin an erase |
| erase_all | input | 1 | With erase_start: whole-chip erase |
| erase_sect | input | SW | With erase_start: sector to erase |
| suspend_req | input | 1 | Request to pause a running erase |
| resume_req | input | 1 | Request to continue a paused erase |
| rd_en | input | 1 | Host read strobe |
| rd_sect | input | SW | Sector of the read address |
| array_q | input | DW | Array data at the read address |
| rd_q | output | DW | Read result, valid the cycle after rd_en |
| ready | output | 1 | 1 = ready, 0 = busy |

## Verification
The bench programs bytes with bit 7 set and with bit 7 clear. This shows that the polling bit is the complement of the written data and not a constant.

It runs a single-sector erase with a suspend in the middle and a whole-chip erase. Reads of the erased sector and of a foreign sector during suspend tell array pass-through apart from held status. The low-time totals tell a counter that resumes apart from one that restarts.

Long runs of status reads tell a toggling bit apart from a stuck one. Stray starts, suspends and resumes, and a simultaneous program and erase start, exercise the ignore and priority rules.

// File: rtl/esr_pkg.sv
package esr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PROG  = 2'd1,
        ST_ERASE = 2'd2,
        ST_SUSP  = 2'd3
    } esr_state_e;

    typedef enum logic [1:0] {
        RD_ARRAY  = 2'd0,
        RD_TOGGLE = 2'd1,
        RD_HOLD   = 2'd2
    } rd_kind_e;

    function automatic logic is_running(esr_state_e st);
        return (st == ST_PROG) || (st == ST_ERASE);
    endfunction

    function automatic rd_kind_e classify_read(esr_state_e st, logic sect_hit);
        rd_kind_e k;
        case (st)
            ST_PROG, ST_ERASE: k = RD_TOGGLE;
            ST_SUSP:           k = sect_hit ? RD_HOLD : RD_ARRAY;
            default:           k = RD_ARRAY;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/esr_timer.sv
module esr_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          run,
    output logic          done
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (run && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = run && (cnt_q == CW'(1));

    // Frozen count while paused is what lets a resumed erase continue (R9)
    assert_count_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        (!run && !load) |=> $stable(cnt_q));

    // A finishing count produces a single expiry pulse (R4)
    assert_single_done_R4: assert property (@(posedge clk) disable iff (rst)
        (done && !load) |=> !done);

endmodule

// File: rtl/esr_ctrl.sv
module esr_ctrl
    import esr_pkg::*;
#(
    parameter int DW           = 8,
    parameter int SW           = 4,
    parameter int CW           = 8,
    parameter int PROG_CYCLES  = 16,
    parameter int ERASE_CYCLES = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          prog_start,
    input  logic [DW-1:0] prog_byte,
    input  logic          erase_start,
    input  logic          erase_all,
    input  logic [SW-1:0] erase_sect,
    input  logic          suspend_req,
    input  logic          resume_req,
    input  logic          done,
    output esr_state_e    state,
    output logic          load,
    output logic [CW-1:0] load_val,
    output logic          run,
    output logic          poll_bit,
    output logic [SW-1:0] tgt_sect,
    output logic          tgt_all,
    output logic          ready
);
    esr_state_e state_q, state_d;
    logic       poll_q;
    logic [SW-1:0] sect_q;
    logic       all_q;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: begin
                if (prog_start)       state_d = ST_PROG;
                else if (erase_start) state_d = ST_ERASE;
            end
            ST_PROG: begin
                if (done) state_d = ST_IDLE;
            end
            ST_ERASE: begin
                if (done)             state_d = ST_IDLE;
                else if (suspend_req) state_d = ST_SUSP;
            end
            ST_SUSP: begin
                if (resume_req) state_d = ST_ERASE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign load     = (state_q == ST_IDLE) && (prog_start || erase_start);
    assign load_val = prog_start ? CW'(PROG_CYCLES) : CW'(ERASE_CYCLES);
    assign run      = is_running(state_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            poll_q  <= 1'b0;
            sect_q  <= '0;
            all_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE) begin
                if (prog_start) begin
                    poll_q <= ~prog_byte[DW-1];
                end else if (erase_start) begin
                    poll_q <= 1'b0;
                    sect_q <= erase_sect;
                    all_q  <= erase_all;
                end
            end
        end
    end

    assign state    = state_q;
    assign poll_bit = poll_q;
    assign tgt_sect = sect_q;
    assign tgt_all  = all_q;
    assign ready    = (state_q == ST_IDLE) || (state_q == ST_SUSP);

    assert_busy_after_start_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && (prog_start || erase_start)) |=> !ready);

    assert_auto_return_R4: assert property (@(posedge clk) disable iff (rst)
        done |=> (state_q == ST_IDLE));

    assert_prog_no_suspend_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PROG && !done) |=> (state_q == ST_PROG));

    assert_start_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SUSP && !resume_req) |=> (state_q == ST_SUSP));

endmodule

// File: rtl/esr_readout.sv
module esr_readout
    import esr_pkg::*;
#(
    parameter int DW = 8,
    parameter int SW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  esr_state_e    state,
    input  logic          poll_bit,
    input  logic [SW-1:0] tgt_sect,
    input  logic          tgt_all,
    input  logic          rd_en,
    input  logic [SW-1:0] rd_sect,
    input  logic [DW-1:0] array_q,
    output logic [DW-1:0] rd_q
);
    localparam int LOW_W = DW - 2;

    logic          tog_q;
    logic [DW-1:0] rd_q_r;
    logic          sect_hit;
    rd_kind_e      kind;
    logic [DW-1:0] status_word;

    assign sect_hit    = tgt_all || (rd_sect == tgt_sect);
    assign kind        = classify_read(state, sect_hit);
    assign status_word = {poll_bit, tog_q, {LOW_W{1'b0}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            tog_q  <= 1'b0;
            rd_q_r <= '0;
        end else if (rd_en) begin
            case (kind)
                RD_TOGGLE: begin
                    rd_q_r <= status_word;
                    tog_q  <= ~tog_q;
                end
                RD_HOLD:  rd_q_r <= status_word;
                default:  rd_q_r <= array_q;
            endcase
        end
    end

    assign rd_q = rd_q_r;

    assert_idle_passthru_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && state == ST_IDLE) |=> (rd_q == $past(array_q)));

    assert_toggle_flip_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_en && is_running(state)) |=> (rd_q[DW-2] != tog_q));

    assert_susp_foreign_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_en && state == ST_SUSP && !tgt_all && rd_sect != tgt_sect)
            |=> (rd_q == $past(array_q)));

endmodule

// File: rtl/flash_status_reporter.sv
module flash_status_reporter
    import esr_pkg::*;
#(
    parameter int DW           = 8,
    parameter int SW           = 4,
    parameter int PROG_CYCLES  = 16,
    parameter int ERASE_CYCLES = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          prog_start,
    input  logic [DW-1:0] prog_byte,
    input  logic          erase_start,
    input  logic          erase_all,
    input  logic [SW-1:0] erase_sect,
    input  logic          suspend_req,
    input  logic          resume_req,
    input  logic          rd_en,
    input  logic [SW-1:0] rd_sect,
    input  logic [DW-1:0] array_q,
    output logic [DW-1:0] rd_q,
    output logic          ready
);
    localparam int MAX_CYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int CW      = $clog2(MAX_CYC + 1);

    esr_state_e    state;
    logic          load;
    logic [CW-1:0] load_val;
    logic          run;
    logic          done;
    logic          poll_bit;
    logic [SW-1:0] tgt_sect;
    logic          tgt_all;

    esr_ctrl #(
        .DW(DW), .SW(SW), .CW(CW),
        .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
    ) u_ctrl (
        .clk(clk), .rst(rst),
        .prog_start(prog_start), .prog_byte(prog_byte),
        .erase_start(erase_start), .erase_all(erase_all), .erase_sect(erase_sect),
        .suspend_req(suspend_req), .resume_req(resume_req),
        .done(done), .state(state), .load(load), .load_val(load_val), .run(run),
        .poll_bit(poll_bit), .tgt_sect(tgt_sect), .tgt_all(tgt_all), .ready(ready)
    );

    esr_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst(rst), .load(load), .load_val(load_val),
        .run(run), .done(done)
    );

    esr_readout #(.DW(DW), .SW(SW)) u_readout (
        .clk(clk), .rst(rst), .state(state), .poll_bit(poll_bit),
        .tgt_sect(tgt_sect), .tgt_all(tgt_all),
        .rd_en(rd_en), .rd_sect(rd_sect), .array_q(array_q), .rd_q(rd_q)
    );

    assert_reset_ready_R1: assert property (@(posedge clk)
        rst |=> (ready && rd_q == '0));

endmodule

// File: tb/flash_status_reporter_test.sv
module flash_status_reporter_test;
    localparam int DW = 8;
    localparam int SW = 4;
    localparam int PC = 16;
    localparam int EC = 40;

    logic          clk = 0;
    logic          rst = 1;
    logic          prog_start = 0, erase_start = 0, erase_all = 0;
    logic          suspend_req = 0, resume_req = 0, rd_en = 0;
    logic [DW-1:0] prog_byte = '0, array_q = '0;
    logic [SW-1:0] erase_sect = '0, rd_sect = '0;
    logic [DW-1:0] rd_q;
    logic          ready;

    int total = 0, bad = 0, cyc = 0, busy_cnt = 0;
    logic tog_m = 0;
    logic sample_flag = 0;
    logic [DW-1:0] exp_q[$];
    string         tag_q[$];

    always #5 clk = ~clk;

    flash_status_reporter #(.DW(DW), .SW(SW), .PROG_CYCLES(PC), .ERASE_CYCLES(EC)) uut (
        .clk(clk), .rst(rst), .prog_start(prog_start), .prog_byte(prog_byte),
        .erase_start(erase_start), .erase_all(erase_all), .erase_sect(erase_sect),
        .suspend_req(suspend_req), .resume_req(resume_req), .rd_en(rd_en),
        .rd_sect(rd_sect), .array_q(array_q), .rd_q(rd_q), .ready(ready)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops the expected item the cycle after each read strobe
    always @(posedge clk) begin
        cyc <= cyc + 1;
        sample_flag <= rd_en;
    end

    always @(negedge clk) begin
        if (!ready) busy_cnt++;
        if (sample_flag && exp_q.size() > 0) begin
            automatic logic [DW-1:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            check(rd_q == e, t, int'(rd_q), int'(e));
        end
    end

    // driver: one read, expected value pushed to the scoreboard
    task automatic do_read(input logic [SW-1:0] s, input logic [DW-1:0] arr,
                           input logic [DW-1:0] e, input string tag);
        @(negedge clk);
        rd_en = 1; rd_sect = s; array_q = arr;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 0;
    endtask

    function automatic logic [DW-1:0] stat(input logic p, input logic flip);
        logic [DW-1:0] v;
        v = {p, tog_m, 6'b0};
        if (flip) tog_m = ~tog_m;
        return v;
    endfunction

    task automatic wait_ready();
        while (!ready) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(ready == 1, "R1 ready after reset", ready, 1);
        check(rd_q == 0, "R1 rd_q after reset", rd_q, 0);

        do_read(0, 8'h5A, 8'h5A, "R7 idle read");
        do_read(3, 8'h0F, 8'h0F, "R7 idle read 2");

        // program A5 with a simultaneous erase start (program wins)
        @(negedge clk);
        busy_cnt = 0;
        prog_start = 1; prog_byte = 8'hA5; erase_start = 1; erase_sect = 2;
        @(negedge clk);
        prog_start = 0; erase_start = 0;
        check(ready == 0, "R3 busy after start", ready, 0);
        do_read(0, 8'h11, stat(1'b0, 1'b1), "R5 poll complement");
        do_read(7, 8'h22, stat(1'b0, 1'b1), "R2 toggle");
        @(negedge clk); suspend_req = 1;
        @(negedge clk); suspend_req = 0;
        check(ready == 0, "R8 suspend ignored in program", ready, 0);
        @(negedge clk); erase_start = 1; erase_sect = 4;
        @(negedge clk); erase_start = 0;
        do_read(0, 8'h33, stat(1'b0, 1'b1), "R2 toggle 3");
        wait_ready();
        check(busy_cnt == PC, "R4 program duration R11", busy_cnt, PC);
        do_read(0, 8'hA5, 8'hA5, "R4 auto return to array");

        // program with bit7 clear
        @(negedge clk);
        busy_cnt = 0;
        prog_start = 1; prog_byte = 8'h3C;
        @(negedge clk); prog_start = 0;
        do_read(1, 8'h00, stat(1'b1, 1'b1), "R5 poll complement bit7=0");
        wait_ready();
        check(busy_cnt == PC, "R4 program duration 2", busy_cnt, PC);

        // sector erase with suspend
        @(negedge clk);
        busy_cnt = 0;
        erase_start = 1; erase_sect = 2; erase_all = 0;
        @(negedge clk); erase_start = 0;
        do_read(2, 8'h44, stat(1'b0, 1'b1), "R6 erase poll 0");
        do_read(5, 8'h55, stat(1'b0, 1'b1), "R2 toggle in erase");
        @(negedge clk); suspend_req = 1;
        @(negedge clk); suspend_req = 0;
        check(ready == 1, "R8 ready in suspend", ready, 1);
        do_read(5, 8'h3C, 8'h3C, "R10 foreign sector array");
        do_read(2, 8'h66, stat(1'b0, 1'b0), "R10 erased sector held");
        do_read(2, 8'h66, stat(1'b0, 1'b0), "R10 erased sector held 2");
        @(negedge clk); prog_start = 1; prog_byte = 8'h00;
        @(negedge clk); prog_start = 0;
        check(ready == 1, "R3 start ignored in suspend", ready, 1);
        @(negedge clk); resume_req = 1;
        @(negedge clk); resume_req = 0;
        check(ready == 0, "R8 busy after resume", ready, 0);
        do_read(2, 8'h77, stat(1'b0, 1'b1), "R6 erase poll after resume");
        wait_ready();
        check(busy_cnt == EC, "R9 erase total with suspend", busy_cnt, EC);
        do_read(2, 8'hFF, 8'hFF, "R6 erased data after end");

        // whole-chip erase with suspend
        @(negedge clk);
        busy_cnt = 0;
        erase_start = 1; erase_sect = 1; erase_all = 1;
        @(negedge clk); erase_start = 0; erase_all = 0;
        @(negedge clk); suspend_req = 1;
        @(negedge clk); suspend_req = 0;
        do_read(6, 8'h88, stat(1'b0, 1'b0), "R10 chip erase any sector held");
        @(negedge clk); resume_req = 1;
        @(negedge clk); resume_req = 0;
        wait_ready();
        check(busy_cnt == EC, "R9 chip erase total", busy_cnt, EC);

        // plain erase, no suspend
        @(negedge clk);
        busy_cnt = 0;
        erase_start = 1; erase_sect = 9;
        @(negedge clk); erase_start = 0;
        wait_ready();
        check(busy_cnt == EC, "R6 erase duration", busy_cnt, EC);

        // stray resume in idle
        @(negedge clk); resume_req = 1;
        @(negedge clk); resume_req = 0;
        check(ready == 1, "R8 resume ignored in idle", ready, 1);
        do_read(0, 8'h99, 8'h99, "R7 idle after stray resume");
        do_read(2, 8'h00, stat(1'b1, 1'b0) & 8'h00, "R7 idle zero");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule